// File: doc/BRIEF.md
# Timer Tick Source Selector

This block decides when an 8-bit timer counter may advance. Each cycle it raises a one-cycle count-enable pulse, `tick_o`, or leaves it low. A three-bit select input picks the source of that pulse. The timer can be held still. It can count every system clock, or count one of four fixed divisions of the system clock. It can also count falling or rising edges seen on an external input pin. The counter that consumes the pulse and any register decoding live outside this block.

A free-running 10-bit prescale counter starts at zero on reset and advances on every clock, whatever the selection. A divided mode fires on the cycle in which the low bits that belong to its ratio are all ones. Because the counter is never restarted, a change of selection keeps the existing phase. The external pin is asynchronous. It passes through two flip-flops, and a third register holds the previous synchronized level for edge detection. Each clean edge of the selected polarity gives exactly one pulse, two clock cycles after the pin changes.

As an example of scale, an 8 MHz clock divided by 1024 gives 7812.5 pulses per second. At that rate an 8-bit counter wraps about every 32.768 ms. The block has no data stream, so every pin is a plain level and there is no handshake.

Top module: `tmr_tick_gen`

## Requirements
- R1: Select code 0 (stopped) keeps tick_o low on every cycle.
- R2: Select code 1 drives tick_o high on every cycle.
- R3: Select code 2 gives exactly one tick in every 8 consecutive cycles, with ticks spaced exactly 8 cycles apart.
- R4: Select code 3 gives one tick every 64 cycles, with ticks spaced exactly 64 apart.
- R5: Select code 4 gives one tick every 256 cycles, with ticks spaced exactly 256 apart.
- R6: Select code 5 gives one tick every 1024 cycles, with ticks spaced exactly 1024 apart.
- R7: Select code 6 gives exactly one tick for each high-to-low change of ext_pin_i. The tick is high during the second clock cycle after the change is first sampled and low in the cycle after that.
- R8: Select code 7 gives exactly one tick for each low-to-high change of ext_pin_i, with the same two-cycle latency as R7.
- R9: In the external modes (select codes 6 and 7), a pin change of the opposite polarity, or a pin held steady, produces no tick. In select codes 2 to 7, with the select held steady, tick_o is never high on two consecutive cycles.
- R10: While rst_ni is low, tick_o is low for select code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Tick source: 0 stop, 1 every clock, 2/3/4/5 divide by 8/64/256/1024, 6 falling pin edge, 7 rising pin edge |
| ext_pin_i | input | 1 | Raw asynchronous external event pin |
| tick_o | output | 1 | One-cycle count-enable pulse |

## Verification
For each divided mode, the bench measures the spacing between pulses across several periods. A tap placed on the wrong counter bit shows up as a wrong gap or a wrong pulse count in the window. For the external modes it checks the exact cycle in which the pulse appears, two cycles after the pin moves. A synchronizer that is one stage short or long therefore fails the check. It also drives the opposite edge and checks that no pulse appears. A swapped polarity, or a level detector in place of an edge detector, would pulse there or hold the pulse high for several cycles. Stop mode is watched over a full prescale period, which catches a stray tap leaking through.

// File: rtl/tmr_tick_pkg.sv
package tmr_tick_pkg;
  localparam int PRE_W  = 10;
  localparam int NUM_DIV = 4;

  typedef enum logic [2:0] {
    SRC_STOP  = 3'd0,
    SRC_CLK   = 3'd1,
    SRC_DIV8  = 3'd2,
    SRC_DIV64 = 3'd3,
    SRC_DIV256 = 3'd4,
    SRC_DIV1K = 3'd5,
    SRC_FALL  = 3'd6,
    SRC_RISE  = 3'd7
  } tick_src_e;

  // number of low prescale bits that must be all ones for divider idx
  function automatic int tap_bits(input int idx);
    case (idx)
      0: return 3;
      1: return 6;
      2: return 8;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int W = tmr_tick_pkg::PRE_W,
  parameter int N = tmr_tick_pkg::NUM_DIV
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [N-1:0] hit_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < N; i++) begin : g_tap
    localparam int L = tmr_tick_pkg::tap_bits(i);
    assign hit_o[i] = &cnt_q[L-1:0];
  end
endmodule

// File: rtl/tmr_ext_edge.sv
module tmr_ext_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o =  sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[SYNC_STAGES-1] &  prev_q;
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_tick_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  input  logic       ext_pin_i,
  output logic       tick_o
);
  logic [NUM_DIV-1:0] div_hit;
  logic               ext_rise, ext_fall;

  tmr_prescale #(.W(PRE_W), .N(NUM_DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hit_o (div_hit)
  );

  tmr_ext_edge #(.SYNC_STAGES(2)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (ext_pin_i),
    .rise_o(ext_rise),
    .fall_o(ext_fall)
  );

  always_comb begin
    case (tick_src_e'(sel_i))
      SRC_STOP:   tick_o = 1'b0;
      SRC_CLK:    tick_o = 1'b1;
      SRC_DIV8:   tick_o = div_hit[0];
      SRC_DIV64:  tick_o = div_hit[1];
      SRC_DIV256: tick_o = div_hit[2];
      SRC_DIV1K:  tick_o = div_hit[3];
      SRC_FALL:   tick_o = ext_fall;
      SRC_RISE:   tick_o = ext_rise;
      default:    tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_tick_gen_chk.sv
module tmr_tick_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] sel_i,
  input logic       ext_pin_i,
  input logic       tick_o
);
  assert_stop_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd0) |-> !tick_o);

  assert_every_clk_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd1) |-> tick_o);

  assert_fall_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd6 && tick_o) |-> !$past(ext_pin_i, 2));

  assert_rise_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd7 && tick_o) |-> $past(ext_pin_i, 2));

  assert_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i >= 3'd2) |=> !(tick_o && $stable(sel_i)));
endmodule

bind tmr_tick_gen tmr_tick_gen_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_i    (sel_i),
  .ext_pin_i(ext_pin_i),
  .tick_o   (tick_o)
);

// File: tb/tmr_tick_gen_tb_top.sv
module tmr_tick_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       pin = 1'b0;
  logic       tick;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  tmr_tick_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .ext_pin_i(pin), .tick_o(tick)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    #3;
    check("R10 tick during reset", int'(tick), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_stop();
    int cnt = 0;
    sel = 3'd0;
    for (int i = 0; i < 2100; i++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
    check("R1 ticks while stopped", cnt, 0);
  endtask

  task automatic t_every();
    int cnt = 0;
    sel = 3'd1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
    check("R2 ticks in 50 cycles", cnt, 50);
  endtask

  task automatic t_div(input string req, input logic [2:0] code, input int n);
    int cnt = 0, last = -1, bad_gap = 0, back2back = 0;
    bit prev = 1'b0;
    sel = code;
    for (int i = 0; i < 4 * n; i++) begin
      @(negedge clk);
      if (tick) begin
        cnt++;
        if (last >= 0 && (i - last) != n) bad_gap++;
        last = i;
      end
      if (tick && prev) back2back++;
      prev = tick;
    end
    check({req, " tick count in 4 periods"}, cnt, 4);
    check({req, " wrong gaps"}, bad_gap, 0);
    check({req, " R9 back-to-back ticks"}, back2back, 0);
  endtask

  // drive an edge of the pin; expect tick pattern 0,1,0,0,0,0 if wanted
  task automatic t_edge(input string req, input logic [2:0] code,
                        input logic new_lvl, input bit want);
    sel = code;
    @(negedge clk);
    pin = new_lvl;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      check($sformatf("%s cycle %0d after edge", req, i), int'(tick),
            (want && i == 2) ? 1 : 0);
    end
  endtask

  initial begin
    t_reset();
    t_stop();
    t_every();
    t_div("R3", 3'd2, 8);
    t_div("R4", 3'd3, 64);
    t_div("R5", 3'd4, 256);
    t_div("R6", 3'd5, 1024);
    sel = 3'd0; pin = 1'b1;
    repeat (5) @(negedge clk);
    t_edge("R7 fall", 3'd6, 1'b0, 1'b1);
    t_edge("R9 rise ignored in fall mode", 3'd6, 1'b1, 1'b0);
    t_edge("R9 steady pin in fall mode", 3'd6, 1'b1, 1'b0);
    t_edge("R9 fall ignored in rise mode", 3'd7, 1'b0, 1'b0);
    t_edge("R8 rise", 3'd7, 1'b1, 1'b1);
    t_edge("R8 second rise after fall", 3'd7, 1'b0, 1'b0);
    t_edge("R8 rise again", 3'd7, 1'b1, 1'b1);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule